// File: doc/BRIEF.md
# Evicted-Address Reuse Predictor

This block predicts whether a block that has just missed in a cache is likely to be reused. It keeps an approximate record of recently evicted block addresses in a bit vector. Two hash functions index the vector. When the cache evicts a block, the block's address is added to the record. When the cache misses, the missed address is looked up. A hit means the block left the cache only a short time ago, so the block is inserted at the most-recently-used (MRU) end. A miss in the record means low expected reuse. In that case a bimodal rule applies: one low-reuse insertion in every `BIP_PERIOD` goes to MRU, and all the others go to the least-recently-used (LRU) end.

The record is approximate. It can report false positives, but it never reports false negatives, and individual addresses are never removed from it. To keep a large working set from filling the record, the whole vector is cleared in bulk when an insertion counter reaches the record's nominal capacity. An optional second counter tracks high-priority (MRU) insertions and also triggers a bulk clear when it reaches the number of blocks in the cache. The cache arrays and the replacement state live outside this block. It sees only an eviction port and a miss port, and it returns one registered insert-position decision per miss.

Top module: `evict_reuse_predictor`

## Requirements
- R1: After reset the vector is empty, both clear counters and the bimodal counter are zero, and `decision_valid` is 0. The first miss after reset on any address therefore yields `decision_mru` = 0.
- R2: An eviction sets two vector bits: h0, the XOR-fold of the address onto `IDX_W` bits, and h1, the XOR-fold of the bit-reversed address. Address bit i lands at index bit i mod `IDX_W`. A later miss on that address, with no bulk clear in between, reports present.
- R3: A lookup reports present only when both hashed bits are set.
- R4: `decision_valid` is 1 in the cycle after a cycle with `miss_valid` = 1, and it is 0 in the cycle after a cycle without one.
- R5: A present lookup gives `decision_mru` = 1, which means insert at MRU.
- R6: An absent lookup gives `decision_mru` = 1 only when the bimodal counter equals `BIP_PERIOD`-1, and 0 otherwise. Every absent miss advances this counter, wrapping to 0 after `BIP_PERIOD`-1. Present misses and bulk clears leave the counter unchanged.
- R7: The insertion counter counts evictions since the last clear. An eviction that arrives while the counter equals `CAPACITY` clears the vector and both counters first, then writes its own address. The counter is then 1.
- R8: When a miss and an eviction occur in the same cycle, the lookup uses the vector as it stood before that cycle's write or clear.
- R9: With `PRIO_CLEAR_EN` = 1, each MRU decision advances the high-priority counter. The MRU decision that finds this counter at `CACHE_BLOCKS`-1 clears the vector and both counters. An eviction in the same cycle is written after the clear.
- R10: The insertion counter never exceeds `CAPACITY`, and the high-priority counter stays below `CACHE_BLOCKS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evict_valid | input | 1 | An eviction occurs this cycle |
| evict_addr | input | ADDR_W | Block address of the evicted line |
| miss_valid | input | 1 | A miss lookup is requested this cycle |
| miss_addr | input | ADDR_W | Block address that missed |
| decision_valid | output | 1 | A decision is presented this cycle |
| decision_mru | output | 1 | 1: insert at MRU, 0: insert at LRU |

## Verification
Each decision is due exactly one rising edge after its miss is presented. An eviction or bulk clear becomes visible to lookups made in the cycle after it. The bench drives inputs on the falling edge and waits for one rising edge. It then samples `decision_valid` and `decision_mru` on the next falling edge, so every result is read in its own cycle. The expected values come from a cycle-level model of the vector, the two clear counters and the bimodal counter. The model is advanced only after each sample, so a same-cycle miss and eviction is judged against the state that existed before that cycle.

// File: rtl/erp_pkg.sv
// Shared types for the evicted-address reuse predictor.
package erp_pkg;
    // Insert position handed back to the cache for a missed block.
    typedef enum logic {
        POS_LRU = 1'b0,
        POS_MRU = 1'b1
    } ins_pos_e;
endpackage

// File: rtl/erp_hash.sv
// XOR-fold hash of a block address onto a vector index.
// SEL = 0 folds the address as is; SEL = 1 folds its bit-reversed form.
// Assumes ADDR_W >= IDX_W.
module erp_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int SEL    = 0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-1:0] src;

    generate
        if (SEL == 0) begin : g_direct
            // Purpose: use the address bits unchanged.
            assign src = addr;
        end else begin : g_reversed
            // Purpose: reverse the address bit order before folding.
            for (genvar b = 0; b < ADDR_W; b++) begin : g_rev
                assign src[b] = addr[ADDR_W-1-b];
            end
        end
    endgenerate

    // Purpose: fold bit i of the source into index bit (i mod IDX_W).
    always_comb begin
        idx = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            idx[i % IDX_W] = idx[i % IDX_W] ^ src[i];
        end
    end
endmodule

// File: rtl/erp_bitvec.sv
// Bit vector holding the approximate evicted-address set.
// A lookup reads the registered vector, so it sees the state from before
// any set or clear issued in the same cycle. A clear wins over old contents,
// and the set bits are applied after it.
// Assumes VEC_BITS is a power of two and IDX_W = log2(VEC_BITS).
module erp_bitvec #(
    parameter int VEC_BITS = 1024,
    parameter int IDX_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx0,
    input  logic [IDX_W-1:0] set_idx1,
    input  logic [IDX_W-1:0] tst_idx0,
    input  logic [IDX_W-1:0] tst_idx1,
    output logic             hit
);
    logic [VEC_BITS-1:0] vec;
    logic [VEC_BITS-1:0] vec_n;

    // Purpose: clear first, then set both hashed bits of an insertion.
    always_comb begin
        vec_n = clr ? '0 : vec;
        if (set_en) begin
            vec_n[set_idx0] = 1'b1;
            vec_n[set_idx1] = 1'b1;
        end
    end

    // Purpose: hold the vector; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) vec <= '0;
        else        vec <= vec_n;
    end

    // Purpose: report present only when both hashed bits are set.
    assign hit = vec[tst_idx0] & vec[tst_idx1];
endmodule

// File: rtl/erp_clear_ctrl.sv
// Bulk-clear control: counts insertions and, optionally, MRU decisions.
// A clear is raised when an insertion arrives with the insertion count at
// CAPACITY, or when an MRU decision arrives with the priority count at
// CACHE_BLOCKS-1 (only if PRIO_CLEAR_EN). A clear resets both counters,
// and an insertion in the same cycle then counts as the first one.
module erp_clear_ctrl #(
    parameter int CAPACITY      = 128,
    parameter int CACHE_BLOCKS  = 256,
    parameter bit PRIO_CLEAR_EN = 1'b1,
    localparam int CNT_W        = $clog2(CAPACITY + 1),
    localparam int HP_W         = $clog2(CACHE_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic             mru_ins,
    output logic             clr,
    output logic [CNT_W-1:0] ins_cnt,
    output logic [HP_W-1:0]  hp_cnt
);
    logic full_hit;
    logic hp_hit;

    assign full_hit = ins_en && (ins_cnt == CNT_W'(CAPACITY));
    assign clr      = full_hit || hp_hit;

    // Purpose: count insertions since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   ins_cnt <= '0;
        else if (clr) ins_cnt <= CNT_W'(ins_en);
        else          ins_cnt <= ins_cnt + CNT_W'(ins_en);
    end

    generate
        if (PRIO_CLEAR_EN) begin : g_prio
            assign hp_hit = mru_ins && (hp_cnt == HP_W'(CACHE_BLOCKS - 1));

            // Purpose: count MRU decisions since the last clear.
            always_ff @(posedge clk) begin
                if (!rst_n)   hp_cnt <= '0;
                else if (clr) hp_cnt <= '0;
                else          hp_cnt <= hp_cnt + HP_W'(mru_ins);
            end
        end else begin : g_no_prio
            assign hp_hit = 1'b0;
            assign hp_cnt = '0;
        end
    endgenerate
endmodule

// File: rtl/erp_bimodal.sv
// Bimodal insertion selector for low-reuse misses: it picks MRU once every
// PERIOD advances. The counter is free-running and is not touched by bulk
// clears. Assumes PERIOD >= 2.
module erp_bimodal #(
    parameter int PERIOD  = 32,
    localparam int BW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic          pick_mru,
    output logic [BW-1:0] cnt
);
    assign pick_mru = (cnt == BW'(PERIOD - 1));

    // Purpose: advance once per low-reuse miss, wrapping at PERIOD-1.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (adv)     cnt <= pick_mru ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/evict_reuse_predictor.sv
// Evicted-address reuse predictor. Evictions are written into a
// two-hash bit vector. Misses are looked up and return, one cycle later,
// an MRU/LRU insert decision: MRU when the address is present, otherwise
// the bimodal choice. The vector is cleared in bulk by erp_clear_ctrl.
// Assumes at most one eviction and one miss per cycle.
module evict_reuse_predictor
    import erp_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int VEC_BITS      = 1024,
    parameter int CAPACITY      = 128,
    parameter int CACHE_BLOCKS  = 256,
    parameter int BIP_PERIOD    = 32,
    parameter bit PRIO_CLEAR_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    output logic              decision_valid,
    output logic              decision_mru
);
    localparam int IDX_W = $clog2(VEC_BITS);
    localparam int CNT_W = $clog2(CAPACITY + 1);
    localparam int HP_W  = $clog2(CACHE_BLOCKS + 1);
    localparam int BW    = $clog2(BIP_PERIOD);

    logic [IDX_W-1:0] idx [2][2];   // [port: 0 evict, 1 miss][hash]
    logic             miss_hit;
    logic             pick_mru;
    logic             low_reuse;
    logic             mru_dec;
    logic             clr;
    logic [CNT_W-1:0] ins_cnt;
    logic [HP_W-1:0]  hp_cnt;
    logic [BW-1:0]    bip_cnt;
    ins_pos_e         pos_q;

    // Two hashes on each of the two address ports.
    generate
        for (genvar p = 0; p < 2; p++) begin : g_port
            for (genvar h = 0; h < 2; h++) begin : g_hash
                erp_hash #(
                    .ADDR_W(ADDR_W),
                    .IDX_W (IDX_W),
                    .SEL   (h)
                ) u_hash (
                    .addr(p == 0 ? evict_addr : miss_addr),
                    .idx (idx[p][h])
                );
            end
        end
    endgenerate

    erp_bitvec #(
        .VEC_BITS(VEC_BITS),
        .IDX_W   (IDX_W)
    ) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .set_en  (evict_valid),
        .set_idx0(idx[0][0]),
        .set_idx1(idx[0][1]),
        .tst_idx0(idx[1][0]),
        .tst_idx1(idx[1][1]),
        .hit     (miss_hit)
    );

    assign low_reuse = miss_valid && !miss_hit;
    assign mru_dec   = miss_valid && (miss_hit || pick_mru);

    erp_bimodal #(
        .PERIOD(BIP_PERIOD)
    ) u_bip (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (low_reuse),
        .pick_mru(pick_mru),
        .cnt     (bip_cnt)
    );

    erp_clear_ctrl #(
        .CAPACITY     (CAPACITY),
        .CACHE_BLOCKS (CACHE_BLOCKS),
        .PRIO_CLEAR_EN(PRIO_CLEAR_EN)
    ) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ins_en (evict_valid),
        .mru_ins(mru_dec),
        .clr    (clr),
        .ins_cnt(ins_cnt),
        .hp_cnt (hp_cnt)
    );

    // Purpose: register the decision one cycle after the miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decision_valid <= 1'b0;
            pos_q          <= POS_LRU;
        end else begin
            decision_valid <= miss_valid;
            pos_q          <= (miss_hit || pick_mru) ? POS_MRU : POS_LRU;
        end
    end

    assign decision_mru = (pos_q == POS_MRU);
endmodule

// File: rtl/erp_checker.sv
// Protocol and bound checks for evict_reuse_predictor, attached by bind.
module erp_checker #(
    parameter int CAPACITY     = 128,
    parameter int CACHE_BLOCKS = 256,
    parameter int CNT_W        = 8,
    parameter int HP_W         = 9,
    parameter int BW           = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evict_valid,
    input logic             miss_valid,
    input logic             miss_hit,
    input logic             decision_valid,
    input logic             decision_mru,
    input logic [CNT_W-1:0] ins_cnt,
    input logic [HP_W-1:0]  hp_cnt,
    input logic [BW-1:0]    bip_cnt
);
    p_valid_follows_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> decision_valid);

    p_no_stray_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> !decision_valid);

    p_hit_gives_mru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && miss_hit) |=> decision_mru);

    p_bip_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!miss_valid || miss_hit) |=> $stable(bip_cnt));

    p_wrap_on_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && ins_cnt == CNT_W'(CAPACITY)) |=> (ins_cnt == CNT_W'(1)));

    p_ins_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_cnt <= CNT_W'(CAPACITY));

    p_hp_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hp_cnt < HP_W'(CACHE_BLOCKS));
endmodule

bind evict_reuse_predictor erp_checker #(
    .CAPACITY    (CAPACITY),
    .CACHE_BLOCKS(CACHE_BLOCKS),
    .CNT_W       (CNT_W),
    .HP_W        (HP_W),
    .BW          (BW)
) i_erp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .evict_valid   (evict_valid),
    .miss_valid    (miss_valid),
    .miss_hit      (miss_hit),
    .decision_valid(decision_valid),
    .decision_mru  (decision_mru),
    .ins_cnt       (ins_cnt),
    .hp_cnt        (hp_cnt),
    .bip_cnt       (bip_cnt)
);

// File: tb/test_evict_reuse_predictor.sv
// Directed bench for evict_reuse_predictor with a cycle-level reference model.
module test_evict_reuse_predictor;
    localparam int AW   = 32;
    localparam int VB   = 1024;
    localparam int IW   = 10;
    localparam int CAP  = 16;
    localparam int CB   = 12;
    localparam int BIPP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          evict_valid = 1'b0;
    logic [AW-1:0] evict_addr = '0;
    logic          miss_valid = 1'b0;
    logic [AW-1:0] miss_addr = '0;
    logic          decision_valid;
    logic          decision_mru;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Reference model state
    logic [VB-1:0] m_bits = '0;
    int m_ins = 0;
    int m_hp  = 0;
    int m_bip = 0;

    evict_reuse_predictor #(
        .ADDR_W(AW), .VEC_BITS(VB), .CAPACITY(CAP),
        .CACHE_BLOCKS(CB), .BIP_PERIOD(BIPP), .PRIO_CLEAR_EN(1'b1)
    ) i_evict_reuse_predictor (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_addr(evict_addr),
        .miss_valid(miss_valid), .miss_addr(miss_addr),
        .decision_valid(decision_valid), .decision_mru(decision_mru)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails = fails + 1;
            $display("FAIL R4 watchdog expired: act=%0d cycles exp<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [IW-1:0] hsh(input logic [AW-1:0] a, input bit rev);
        logic [IW-1:0] r = '0;
        for (int i = 0; i < AW; i++) begin
            r[i % IW] = r[i % IW] ^ (rev ? a[AW-1-i] : a[i]);
        end
        return r;
    endfunction

    function automatic logic m_present(input logic [AW-1:0] a);
        return m_bits[hsh(a, 1'b0)] & m_bits[hsh(a, 1'b1)];
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
        end
    endtask

    // One cycle: drive, let one rising edge pass, sample, then advance the model.
    task automatic step(input logic ev, input logic [AW-1:0] ea,
                        input logic ms, input logic [AW-1:0] ma, input string req);
        logic hit_m, pick_m, mru_m, clr_m;
        hit_m  = m_present(ma);
        pick_m = (m_bip == BIPP - 1);
        mru_m  = hit_m || pick_m;
        evict_valid = ev; evict_addr = ea;
        miss_valid  = ms; miss_addr  = ma;
        @(posedge clk);
        @(negedge clk);
        evict_valid = 1'b0;
        miss_valid  = 1'b0;
        chk(decision_valid, ms, "R4 valid timing");
        if (ms) chk(decision_mru, mru_m, req);
        clr_m = (ev && m_ins == CAP) || (ms && mru_m && m_hp == CB - 1);
        if (clr_m) m_bits = '0;
        m_ins = clr_m ? int'(ev) : m_ins + int'(ev);
        m_hp  = clr_m ? 0 : m_hp + int'(ms && mru_m);
        if (ev) begin
            m_bits[hsh(ea, 1'b0)] = 1'b1;
            m_bits[hsh(ea, 1'b1)] = 1'b1;
        end
        if (ms && !hit_m) m_bip = pick_m ? 0 : m_bip + 1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(decision_valid, 1'b0, "R1 valid low after reset");
        step(1'b0, '0, 1'b1, 32'h0000_1234, "R1 first miss goes LRU");
        chk(decision_mru, 1'b0, "R1 empty filter gives LRU");
    endtask

    task automatic t_insert_lookup;
        step(1'b1, 32'hA5A5_0040, 1'b0, '0, "R2");
        step(1'b0, '0, 1'b1, 32'hA5A5_0040, "R2 R5 evicted address present");
        chk(decision_mru, 1'b1, "R5 present gives MRU");
        step(1'b0, '0, 1'b0, '0, "R4 idle");
        step(1'b0, '0, 1'b1, 32'h0F0F_7700, "R3 unseen address");
    endtask

    task automatic t_bimodal;
        for (int i = 0; i < 70; i++) begin
            step(1'b0, '0, 1'b1, 32'h7000_0000 + 32'(i * 4099), "R6 bimodal choice");
        end
    endtask

    task automatic t_same_cycle;
        step(1'b1, 32'h3C3C_1100, 1'b1, 32'h3C3C_1100, "R8 same-cycle uses old state");
        step(1'b0, '0, 1'b1, 32'h3C3C_1100, "R8 visible next cycle");
        chk(decision_mru, 1'b1, "R8 written address present");
    endtask

    task automatic t_capacity;
        for (int i = 0; i < CAP + 4; i++) begin
            step(1'b1, 32'h5000_0000 + 32'(i * 977), 1'b0, '0, "R7");
        end
        step(1'b0, '0, 1'b1, 32'h5000_0000, "R7 early address after wrap");
        step(1'b0, '0, 1'b1, 32'h5000_0000 + 32'((CAP + 3) * 977), "R7 newest address");
        chk(decision_mru, 1'b1, "R7 newest address present after clear");
    endtask

    task automatic t_prio_clear;
        for (int i = 0; i < CB + 2; i++) begin
            step(1'b1, 32'h2222_0000 + 32'(i), 1'b1, 32'h2222_0000 + 32'(i), "R9 paired");
            step(1'b0, '0, 1'b1, 32'h2222_0000 + 32'(i), "R9 MRU counting clear");
        end
        step(1'b0, '0, 1'b1, 32'h2222_0000, "R9 after priority clear");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_insert_lookup();
        t_bimodal();
        t_same_cycle();
        t_capacity();
        t_prio_clear();
        t_bimodal();
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule